// File: doc/BRIEF.md
# Serial Controller FIFO Fill Status

This block holds the four byte queues that sit between a two-wire serial bus controller and the processor: one each for master transmit, master receive, slave transmit and slave receive. Each queue holds at most two bytes. It is written and read through per-queue push and pop strobes. The head byte is always visible on the data output.

A 16-bit status word reports the state of each queue as a 2-bit fill code. The code separates a byte that has only just arrived in an empty queue from a byte that has been held for longer. Two bits of the same word are write-one flush controls for the transmit queues. Each control clears itself once its flush has finished. Flushing the master transmit queue also empties the slave receive queue.

Top module: `ctl_fifo_status`

## Requirements
- R1: After reset the status word reads 0x0000, every empty_o bit is 1 and every full_o bit is 0.
- R2: The status word places the fill codes at master receive [7:6], master transmit [5:4], slave receive [3:2] and slave transmit [1:0]. Queue index 0 is master transmit, 1 master receive, 2 slave transmit and 3 slave receive for the strobe, flag and data vectors. Byte i occupies bits [8i+7:8i].
- R3: Fill code 2'b01 appears in the cycle after a push into an empty queue. If the queue still holds one byte in the following cycle, the code becomes 2'b10. Code 2'b00 means empty.
- R4: A queue holding two bytes reports code 2'b11 and asserts full_o. The fill count never exceeds two.
- R5: Bytes leave a queue in the order they entered it. The head byte is presented on pop_data_o whenever the queue is not empty.
- R6: A push into a full queue, or a pop from an empty queue, is ignored and leaves the queue contents and code unchanged.
- R7: Writing 1 to status bit 9 makes that bit read 1 for one cycle. At the end of that cycle the master transmit and slave receive queues are emptied and the bit reads 0 again.
- R8: Writing 1 to status bit 8 makes that bit read 1 for one cycle. At the end of that cycle only the slave transmit queue is emptied, and the bit returns to 0.
- R9: A flush overrides a push or pop to the flushed queue in the same cycle. The queue is empty afterwards.
- R10: Bits 15:10 always read 0. Writing 0 to any status bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Status word write strobe |
| reg_wdata_i | input | 16 | Status word write data |
| reg_rdata_o | output | 16 | Status word read value |
| push_i | input | 4 | Push strobe per queue |
| push_data_i | input | 32 | Push byte per queue |
| pop_i | input | 4 | Pop strobe per queue |
| pop_data_o | output | 32 | Head byte per queue |
| full_o | output | 4 | Queue holds two bytes |
| empty_o | output | 4 | Queue holds no bytes |

## Verification
The assertions need no condition on the inputs. Pushes on a full queue, pops on an empty one, simultaneous push and pop, and flush writes that land while a flush is in progress are all legal, and the properties are written to hold for each of them. The random stimulus therefore draws strobes and flush writes freely, with no filtering. Directed sequences force the overflow, underflow, flush-collision and reserved-bit writes that random draws reach only rarely.

// File: rtl/fifo_stat_pkg.sv
package fifo_stat_pkg;
  parameter int BYTE_W   = 8;
  parameter int NUM_FIFO = 4;

  localparam int Q_MTX = 0;
  localparam int Q_MRX = 1;
  localparam int Q_STX = 2;
  localparam int Q_SRX = 3;

  typedef enum logic [1:0] {
    FILL_EMPTY = 2'b00,
    FILL_FRESH = 2'b01,
    FILL_ONE   = 2'b10,
    FILL_FULL  = 2'b11
  } fill_code_e;
endpackage

// File: rtl/pair_fifo.sv
module pair_fifo
  import fifo_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output fill_code_e        code_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam logic [1:0] CAP = 2'd2;

  logic [1:0][DATA_W-1:0] mem_q;
  logic [1:0]             cnt_q;
  logic                   rd_q, wr_q, fresh_q;
  logic                   do_push, do_pop;

  assign do_push = push_i && (cnt_q != CAP);
  assign do_pop  = pop_i && (cnt_q != 2'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q   <= '0;
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      fresh_q <= 1'b0;
    end else if (flush_i) begin
      cnt_q   <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= ~wr_q;
      end
      if (do_pop) rd_q <= ~rd_q;
      cnt_q   <= cnt_q + {1'b0, do_push} - {1'b0, do_pop};
      // only a first byte into an empty queue counts as just written
      fresh_q <= do_push && !do_pop && (cnt_q == 2'd0);
    end
  end

  always_comb begin
    unique case (cnt_q)
      2'd0:    code_o = FILL_EMPTY;
      2'd1:    code_o = fresh_q ? FILL_FRESH : FILL_ONE;
      default: code_o = FILL_FULL;
    endcase
  end

  assign head_o  = mem_q[rd_q];
  assign full_o  = (cnt_q == CAP);
  assign empty_o = (cnt_q == 2'd0);

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CAP);

  // R3
  fresh_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && empty_o && !flush_i) |=> (code_o == FILL_FRESH));

  // R6
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(head_o)));

  // R6
  empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> empty_o);

  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && code_o == FILL_EMPTY));
endmodule

// File: rtl/ctl_fifo_status.sv
module ctl_fifo_status
  import fifo_stat_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_we_i,
  input  logic [15:0]                  reg_wdata_i,
  output logic [15:0]                  reg_rdata_o,
  input  logic [NUM_FIFO-1:0]          push_i,
  input  logic [NUM_FIFO*BYTE_W-1:0]   push_data_i,
  input  logic [NUM_FIFO-1:0]          pop_i,
  output logic [NUM_FIFO*BYTE_W-1:0]   pop_data_o,
  output logic [NUM_FIFO-1:0]          full_o,
  output logic [NUM_FIFO-1:0]          empty_o
);
  localparam int FL_MT_BIT = 9;
  localparam int FL_ST_BIT = 8;

  logic                       flush_mt_q, flush_st_q;
  logic [NUM_FIFO-1:0]        flush;
  fill_code_e [NUM_FIFO-1:0]  code;
  logic                       unused_wdata;

  assign unused_wdata = ^{reg_wdata_i[15:10], reg_wdata_i[7:0]};

  // a flag lives exactly one cycle: the cycle in which its flush is applied
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flush_mt_q <= 1'b0;
      flush_st_q <= 1'b0;
    end else begin
      flush_mt_q <= reg_we_i && reg_wdata_i[FL_MT_BIT];
      flush_st_q <= reg_we_i && reg_wdata_i[FL_ST_BIT];
    end
  end

  always_comb begin
    flush        = '0;
    flush[Q_MTX] = flush_mt_q;
    flush[Q_SRX] = flush_mt_q;
    flush[Q_STX] = flush_st_q;
  end

  for (genvar g = 0; g < NUM_FIFO; g++) begin : g_q
    pair_fifo #(.DATA_W(BYTE_W)) u_q (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .flush_i (flush[g]),
      .push_i  (push_i[g]),
      .data_i  (push_data_i[g*BYTE_W +: BYTE_W]),
      .pop_i   (pop_i[g]),
      .head_o  (pop_data_o[g*BYTE_W +: BYTE_W]),
      .code_o  (code[g]),
      .full_o  (full_o[g]),
      .empty_o (empty_o[g])
    );
  end

  assign reg_rdata_o = {6'b0, flush_mt_q, flush_st_q,
                        code[Q_MRX], code[Q_MTX], code[Q_SRX], code[Q_STX]};

  // R7
  mt_selfclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_mt_q && !(reg_we_i && reg_wdata_i[FL_MT_BIT])) |=> !reg_rdata_o[FL_MT_BIT]);

  // R7
  mt_flush_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[FL_MT_BIT] |=> (empty_o[Q_MTX] && empty_o[Q_SRX]));

  // R8
  st_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[FL_ST_BIT] |=> empty_o[Q_STX]);

  // R10
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[15:10] == 6'b0);

  // R4
  full_empty_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o & empty_o) == '0);
endmodule

// File: tb/ctl_fifo_status_tb_top.sv
`timescale 1ns/1ps
module ctl_fifo_status_tb_top;
  localparam int NQ = 4;
  localparam int BW = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             reg_we_i = 1'b0;
  logic [15:0]      reg_wdata_i = '0;
  logic [15:0]      reg_rdata_o;
  logic [NQ-1:0]    push_i = '0;
  logic [NQ*BW-1:0] push_data_i = '0;
  logic [NQ-1:0]    pop_i = '0;
  logic [NQ*BW-1:0] pop_data_o;
  logic [NQ-1:0]    full_o, empty_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // model state
  int        m_cnt [NQ];
  bit        m_fresh [NQ];
  logic [7:0] m_q [NQ][2];
  bit        m_fmt, m_fst;

  always #2.5 clk_i = ~clk_i;

  ctl_fifo_status dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .push_i(push_i), .push_data_i(push_data_i),
    .pop_i(pop_i), .pop_data_o(pop_data_o), .full_o(full_o), .empty_o(empty_o)
  );

  function automatic logic [1:0] exp_code(int i);
    if (m_cnt[i] == 0) return 2'b00;
    if (m_cnt[i] == 2) return 2'b11;
    return m_fresh[i] ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [15:0] exp_status();
    return {6'b0, m_fmt, m_fst, exp_code(1), exp_code(0), exp_code(3), exp_code(2)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit fl [NQ];
    fl[0] = m_fmt; fl[1] = 0; fl[2] = m_fst; fl[3] = m_fmt;
    for (int i = 0; i < NQ; i++) begin
      if (fl[i]) begin
        m_cnt[i] = 0; m_fresh[i] = 0;
      end else begin
        bit dpo, dpu; int c0;
        c0  = m_cnt[i];
        dpo = pop_i[i] && c0 > 0;
        dpu = push_i[i] && c0 < 2;
        if (dpo) begin m_q[i][0] = m_q[i][1]; m_cnt[i]--; end
        if (dpu) begin m_q[i][m_cnt[i]] = push_data_i[i*BW +: BW]; m_cnt[i]++; end
        m_fresh[i] = dpu && !dpo && c0 == 0;
      end
    end
    m_fmt = reg_we_i && reg_wdata_i[9];
    m_fst = reg_we_i && reg_wdata_i[8];
  endtask

  task automatic compare_all();
    chk("R2 status", {16'h0, reg_rdata_o}, {16'h0, exp_status()});
    for (int i = 0; i < NQ; i++) begin
      chk("R4 full", {31'h0, full_o[i]}, {31'h0, m_cnt[i] == 2});
      chk("R1 empty", {31'h0, empty_o[i]}, {31'h0, m_cnt[i] == 0});
      if (m_cnt[i] > 0) chk("R5 head", {24'h0, pop_data_o[i*BW +: BW]}, {24'h0, m_q[i][0]});
    end
  endtask

  task automatic step(logic [NQ-1:0] pu, logic [NQ*BW-1:0] pd, logic [NQ-1:0] po,
                      logic we, logic [15:0] wd);
    push_i = pu; push_data_i = pd; pop_i = po; reg_we_i = we; reg_wdata_i = wd;
    @(posedge clk_i);
    model_update();
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic idle();
    step('0, '0, '0, 1'b0, 16'h0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    for (int i = 0; i < NQ; i++) begin m_cnt[i] = 0; m_fresh[i] = 0; end
    m_fmt = 0; m_fst = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 reset status", {16'h0, reg_rdata_o}, 32'h0);
    chk("R1 reset empty", {28'h0, empty_o}, 32'hF);
    chk("R1 reset full", {28'h0, full_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: fresh then settled, master tx -> bits 5:4
    step(4'b0001, 32'h000000A1, '0, 1'b0, 16'h0);
    chk("R3 fresh code", {30'h0, reg_rdata_o[5:4]}, 32'h1);
    idle();
    chk("R3 settled code", {30'h0, reg_rdata_o[5:4]}, 32'h2);
    // R4 full
    step(4'b0001, 32'h000000A2, '0, 1'b0, 16'h0);
    chk("R4 full code", {30'h0, reg_rdata_o[5:4]}, 32'h3);
    // R6 push on full ignored
    step(4'b0001, 32'h000000FF, '0, 1'b0, 16'h0);
    chk("R6 push on full", {24'h0, pop_data_o[7:0]}, 32'hA1);
    // R5 order, R6 pop on empty
    step('0, '0, 4'b0001, 1'b0, 16'h0);
    chk("R5 second byte", {24'h0, pop_data_o[7:0]}, 32'hA2);
    step('0, '0, 4'b0001, 1'b0, 16'h0);
    step('0, '0, 4'b0001, 1'b0, 16'h0);
    chk("R6 pop on empty", {31'h0, empty_o[0]}, 32'h1);
    step(4'b0001, 32'h000000B3, '0, 1'b0, 16'h0);
    chk("R6 no stale byte", {24'h0, pop_data_o[7:0]}, 32'hB3);
    step(4'b0001, 32'h000000B4, 4'b0001, 1'b0, 16'h0);

    // fill all, then R7
    step(4'b1111, 32'h11223344, '0, 1'b0, 16'h0);
    step(4'b1111, 32'h55667788, '0, 1'b0, 16'h0);
    step('0, '0, '0, 1'b1, 16'h0200);
    chk("R7 flag reads one", {31'h0, reg_rdata_o[9]}, 32'h1);
    idle();
    chk("R7 flag cleared", {31'h0, reg_rdata_o[9]}, 32'h0);
    chk("R7 mtx srx emptied", {28'h0, empty_o}, 32'h9);
    // R8
    step('0, '0, '0, 1'b1, 16'h0100);
    chk("R8 flag reads one", {31'h0, reg_rdata_o[8]}, 32'h1);
    idle();
    chk("R8 only stx emptied", {28'h0, empty_o}, 32'hD);
    chk("R8 flag cleared", {31'h0, reg_rdata_o[8]}, 32'h0);
    // R9 flush beats push
    step(4'b0001, 32'h000000C1, '0, 1'b1, 16'h0200);
    step(4'b1001, 32'hC2000000 | 32'h000000C2, '0, 1'b0, 16'h0);
    chk("R9 flush beats push", {30'h0, empty_o[3], empty_o[0]}, 32'h3);
    // R10 reserved and zero writes
    step(4'b0100, 32'h00D00000, '0, 1'b0, 16'h0);
    step('0, '0, '0, 1'b1, 16'hFC00);
    chk("R10 reserved zero", {26'h0, reg_rdata_o[15:10]}, 32'h0);
    chk("R10 zero write no effect", {31'h0, empty_o[2]}, 32'h0);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic we;
      logic [15:0] wd;
      we = ($urandom % 16) == 0;
      wd = 16'($urandom);
      step(4'($urandom), $urandom, 4'($urandom), we, wd);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule